// File: doc/BRIEF.md
# Configuration Header Write-Protection Register File

This block stores the 64-byte standard configuration header of one function and decides, byte by byte, what a configuration write may change. The configuration decoder presents one dword write per cycle with four byte-lane enables. Every enabled byte is steered through a policy chosen by the header-type byte the block holds. Header type 0x00 or 0x80 selects the endpoint policy, 0x01 selects the bridge policy, and any other value locks the whole header against writes. Reads are combinational: the selected dword appears on the read port in the same cycle.

The endpoint policy treats the six base-address registers and the expansion-ROM register as address decoders. An address written there is cut down to the region's power-of-two size, and the type bits that software uses to recognise a region keep their value. So a sizing write of all ones reads back as the size mask with the type bits still in place. The command register keeps its five reserved upper bits. In the status register the low byte is fixed, and most of the high byte is write-one-to-clear. The function logic can set those high bits through an event input.

A small two-state controller tells the address-map logic when the decode windows may have moved. It has the states UPD_IDLE and UPD_NOTIFY. UPD_IDLE goes to UPD_NOTIFY when a write lands an enabled lane on the command register or on an endpoint address register. UPD_NOTIFY stays put when another such write arrives and otherwise returns to UPD_IDLE. The pulse output is high exactly while the controller is in UPD_NOTIFY.

Top module: `cfghdr_wpolicy`

## Requirements
- R1: After reset the header reads back the parameterised identifiers at offsets 0..3, revision/class bytes at 8..11, header type at 14, capability pointer at 52, interrupt pin at 61, status low byte at 6, status high byte 0b00000_dd_0 (dd = device-select timing), command zero, and each endpoint base-address register with bit 0 = 1 for I/O and 0 for memory. All other bytes reset to zero.
- R2: For header types 0x00 and 0x80, bytes 8, 9, 10, 11, 14, 52 and 61 ignore writes. Ordinary bytes such as 12, 13, 60 and 56..59 take the written value.
- R3: For header type 0x01, bytes 8, 9, 10, 11, 14, 61 and 56..59 ignore writes. Byte 52 is writable. Bytes 16..39 and 48..51 are plain read/write bytes with no masking.
- R4: For any other header type, no write changes any byte, including the status clear bits.
- R5: Bits 15..11 of the command register (offsets 4..5) never change. Bits 10..0 take the written value.
- R6: Status byte 6 ignores writes. In status byte 7, writing 1 to bits 7..3 or bit 0 clears them. Bits 2..1 never change, and writing 0 leaves a bit as it is.
- R7: A 1 on stat_evt bit k (k in 7..3 or 0) sets status byte 7 bit k. When a set and a write-one-clear hit the same bit in one cycle, the bit ends up set.
- R8: An endpoint base-address register of size S (a power of two) stores the written value with address bits below S forced to zero. Its low 2 bits (I/O) or low 4 bits (memory) keep their value, so an all-ones write reads back ~(S-1) with the type bits intact.
- R9: An endpoint base-address register whose size parameter is zero ignores writes.
- R10: On an endpoint header the expansion-ROM register at 48..51 follows the R8 rule with its own size, keeping its low 4 bits, enable bit included. A ROM size of zero makes it read-only.
- R11: Only bytes whose lane enable is 1 may change. Disabled lanes keep their value.
- R12: map_upd is high for exactly the cycle after a write whose enabled lanes include offset 4 or 5 (endpoint or bridge) or an endpoint byte in 16..39 or 48..51, and is low after any other write or idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one dword |
| wr_dw | input | 4 | Dword index of the write |
| wr_be | input | 4 | Byte-lane enables, bit n covers offset 4*wr_dw+n |
| wr_data | input | 32 | Write data, lane n in bits 8n+7..8n |
| stat_evt | input | 8 | Status high-byte set events from the function logic |
| rd_dw | input | 4 | Dword index to read |
| rd_data | output | 32 | Combinational read data |
| map_upd | output | 1 | One-cycle decode-window update indication |

## Verification
The status high byte can be written and set by the function logic in the same cycle, and the outcome depends on the order in which the two are merged. The bench provokes this directly: it writes ones to every clearable bit while raising one event bit, then expects that bit set and every other clearable bit clear. Random traffic then mixes events into a fraction of the writes. A reference model built from the requirements applies the clear first and the set second, and each result is compared on all four header-type variants.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    localparam int HDR_BYTES   = 64;
    localparam int LANES       = 4;
    localparam int DW_W        = $clog2(HDR_BYTES / LANES);
    localparam int OFF_W       = $clog2(HDR_BYTES);
    localparam int NUM_BARS    = 6;
    localparam int NUM_REGIONS = NUM_BARS + 1;
    localparam int REG_W       = $clog2(NUM_REGIONS);
    localparam int ROM_REGION  = NUM_BARS;

    // byte offsets whose position other logic decodes
    localparam logic [OFF_W-1:0] OFF_CMD_LO  = OFF_W'(4);
    localparam logic [OFF_W-1:0] OFF_CMD_HI  = OFF_W'(5);
    localparam logic [OFF_W-1:0] OFF_STAT_LO = OFF_W'(6);
    localparam logic [OFF_W-1:0] OFF_STAT_HI = OFF_W'(7);
    localparam logic [OFF_W-1:0] OFF_REV     = OFF_W'(8);
    localparam logic [OFF_W-1:0] OFF_PIF     = OFF_W'(9);
    localparam logic [OFF_W-1:0] OFF_SUBCLS  = OFF_W'(10);
    localparam logic [OFF_W-1:0] OFF_BASECLS = OFF_W'(11);
    localparam logic [OFF_W-1:0] OFF_HTYPE   = OFF_W'(14);
    localparam logic [OFF_W-1:0] OFF_BAR0    = OFF_W'(16);
    localparam logic [OFF_W-1:0] OFF_BAR_END = OFF_W'(16 + 4 * NUM_BARS);
    localparam logic [OFF_W-1:0] OFF_EP_ROM  = OFF_W'(48);
    localparam logic [OFF_W-1:0] OFF_CAP     = OFF_W'(52);
    localparam logic [OFF_W-1:0] OFF_BR_ROM  = OFF_W'(56);
    localparam logic [OFF_W-1:0] OFF_IPIN    = OFF_W'(61);

    // command byte 5: bits that writes must not touch
    localparam logic [7:0] CMD_HI_KEEP = 8'hF8;
    // status byte 7: bits cleared by writing one / set by events
    localparam logic [7:0] STAT_HI_W1C = 8'hF9;

    typedef enum logic [1:0] {
        HC_ENDPOINT,
        HC_BRIDGE,
        HC_LOCKED
    } hdr_class_t;

    typedef enum logic [2:0] {
        BK_FIXED,
        BK_FREE,
        BK_CMD_HI,
        BK_STAT_HI,
        BK_REGION
    } byte_kind_t;

    typedef struct packed {
        byte_kind_t       kind;
        logic [REG_W-1:0] region;
        logic             map_hit;
    } lane_info_t;

    function automatic hdr_class_t classify(input logic [7:0] ht);
        case (ht)
            8'h00, 8'h80: return HC_ENDPOINT;
            8'h01:        return HC_BRIDGE;
            default:      return HC_LOCKED;
        endcase
    endfunction

endpackage

// File: rtl/cfg_lane_class.sv
module cfg_lane_class
    import cfgp_pkg::*;
(
    input  hdr_class_t       cls,
    input  logic [OFF_W-1:0] off,
    output lane_info_t       info
);

    logic ident, in_bar, in_ep_rom, in_br_rom, is_cmd;

    always_comb begin
        ident     = (off == OFF_REV)    || (off == OFF_PIF)     ||
                    (off == OFF_SUBCLS) || (off == OFF_BASECLS) ||
                    (off == OFF_HTYPE)  || (off == OFF_IPIN)    ||
                    (off == OFF_STAT_LO);
        in_bar    = (off >= OFF_BAR0) && (off < OFF_BAR_END);
        in_ep_rom = (off[OFF_W-1:2] == OFF_EP_ROM[OFF_W-1:2]);
        in_br_rom = (off[OFF_W-1:2] == OFF_BR_ROM[OFF_W-1:2]);
        is_cmd    = (off == OFF_CMD_LO) || (off == OFF_CMD_HI);
    end

    always_comb begin
        info.kind    = BK_FREE;
        info.region  = '0;
        info.map_hit = 1'b0;
        unique case (cls)
            HC_ENDPOINT: begin
                if (ident || off == OFF_CAP) begin
                    info.kind = BK_FIXED;
                end else if (off == OFF_CMD_HI) begin
                    info.kind = BK_CMD_HI;
                end else if (off == OFF_STAT_HI) begin
                    info.kind = BK_STAT_HI;
                end else if (in_bar) begin
                    info.kind   = BK_REGION;
                    info.region = REG_W'((off - OFF_BAR0) >> 2);
                end else if (in_ep_rom) begin
                    info.kind   = BK_REGION;
                    info.region = REG_W'(ROM_REGION);
                end
                info.map_hit = is_cmd || in_bar || in_ep_rom;
            end
            HC_BRIDGE: begin
                if (ident || in_br_rom) begin
                    info.kind = BK_FIXED;
                end else if (off == OFF_CMD_HI) begin
                    info.kind = BK_CMD_HI;
                end else if (off == OFF_STAT_HI) begin
                    info.kind = BK_STAT_HI;
                end
                info.map_hit = is_cmd;
            end
            default: begin
                info.kind = BK_FIXED;
            end
        endcase
    end

endmodule

// File: rtl/cfg_region_byte.sv
module cfg_region_byte
    import cfgp_pkg::*;
#(
    parameter logic [NUM_REGIONS-1:0][31:0] REGION_SIZE = '0,
    parameter logic [NUM_BARS-1:0]          BAR_IS_IO   = '0
) (
    input  logic [REG_W-1:0] region,
    input  logic [1:0]       sub,
    input  logic [7:0]       old_b,
    input  logic [7:0]       wr_b,
    output logic [7:0]       new_b
);

    logic [NUM_REGIONS-1:0][31:0] keep_mask;
    logic [NUM_REGIONS-1:0]       present;

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
        if (r < NUM_BARS) begin : g_bar
            localparam logic [31:0] TYPE_BITS = BAR_IS_IO[r] ? 32'h3 : 32'hF;
            assign keep_mask[r] = (REGION_SIZE[r] - 32'd1) | TYPE_BITS;
        end else begin : g_rom
            assign keep_mask[r] = (REGION_SIZE[r] - 32'd1) | 32'hF;
        end
        assign present[r] = (REGION_SIZE[r] != 32'd0);
    end

    logic [31:0] sel_mask;
    logic        sel_present;
    logic [7:0]  keep_b;

    always_comb begin
        sel_mask    = '0;
        sel_present = 1'b0;
        if (region < REG_W'(NUM_REGIONS)) begin
            sel_mask    = keep_mask[region];
            sel_present = present[region];
        end
        keep_b = sel_mask[{sub, 3'b000} +: 8];
        new_b  = sel_present ? ((wr_b & ~keep_b) | (old_b & keep_b)) : old_b;
    end

endmodule

// File: rtl/cfg_update_fsm.sv
module cfg_update_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic map_upd
);

    typedef enum logic {
        UPD_IDLE,
        UPD_NOTIFY
    } upd_state_t;

    upd_state_t state_q, state_d;

    always_comb begin
        unique case (state_q)
            UPD_IDLE:   state_d = trig ? UPD_NOTIFY : UPD_IDLE;
            UPD_NOTIFY: state_d = trig ? UPD_NOTIFY : UPD_IDLE;
            default:    state_d = UPD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= UPD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            UPD_NOTIFY: map_upd = 1'b1;
            default:    map_upd = 1'b0;
        endcase
    end

    // R12
    upd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        map_upd |-> $past(trig));

    // R12
    upd_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> map_upd);

endmodule

// File: rtl/cfghdr_wpolicy.sv
module cfghdr_wpolicy
    import cfgp_pkg::*;
#(
    parameter logic [7:0]                   HDR_TYPE    = 8'h00,
    parameter logic [15:0]                  VENDOR_ID   = 16'hA5C3,
    parameter logic [15:0]                  DEVICE_ID   = 16'h7E01,
    parameter logic [7:0]                   REV_ID      = 8'h03,
    parameter logic [7:0]                   PROG_IF     = 8'h01,
    parameter logic [7:0]                   SUB_CLASS   = 8'h80,
    parameter logic [7:0]                   BASE_CLASS  = 8'h0C,
    parameter logic [7:0]                   CAP_PTR     = 8'h40,
    parameter logic [7:0]                   INT_PIN     = 8'h01,
    parameter logic [7:0]                   STATUS_LO   = 8'h10,
    parameter logic [1:0]                   DEVSEL      = 2'b01,
    parameter logic [NUM_REGIONS-1:0][31:0] REGION_SIZE = {32'd2048, 32'd0, 32'd256, 32'd16,
                                                           32'd0, 32'd32, 32'd4096},
    parameter logic [NUM_BARS-1:0]          BAR_IS_IO   = 6'b010010
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [DW_W-1:0]      wr_dw,
    input  logic [LANES-1:0]     wr_be,
    input  logic [8*LANES-1:0]   wr_data,
    input  logic [7:0]           stat_evt,
    input  logic [DW_W-1:0]      rd_dw,
    output logic [8*LANES-1:0]   rd_data,
    output logic                 map_upd
);

    localparam hdr_class_t RESET_CLS = classify(HDR_TYPE);

    function automatic logic [7:0] init_byte(input int i);
        if (i == 0)  return VENDOR_ID[7:0];
        if (i == 1)  return VENDOR_ID[15:8];
        if (i == 2)  return DEVICE_ID[7:0];
        if (i == 3)  return DEVICE_ID[15:8];
        if (i == 6)  return STATUS_LO;
        if (i == 7)  return {5'b0, DEVSEL, 1'b0};
        if (i == 8)  return REV_ID;
        if (i == 9)  return PROG_IF;
        if (i == 10) return SUB_CLASS;
        if (i == 11) return BASE_CLASS;
        if (i == 14) return HDR_TYPE;
        if (i == 52) return CAP_PTR;
        if (i == 61) return INT_PIN;
        if (RESET_CLS == HC_ENDPOINT && i >= 16 && i < 16 + 4 * NUM_BARS && (i % 4) == 0)
            return {7'b0, BAR_IS_IO[(i - 16) / 4]};
        return 8'h00;
    endfunction

    logic [7:0] hdr_q [HDR_BYTES];

    hdr_class_t cls;
    assign cls = classify(hdr_q[OFF_HTYPE]);

    logic [LANES-1:0][7:0] lane_new;
    logic [LANES-1:0]      lane_map;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam logic [1:0] LSUB = 2'(l);

        logic [OFF_W-1:0] off;
        lane_info_t       info;
        logic [7:0]       old_b, wr_b, reg_b, nv;

        assign off   = {wr_dw, LSUB};
        assign old_b = hdr_q[off];
        assign wr_b  = wr_data[8*l +: 8];

        cfg_lane_class u_class (
            .cls  (cls),
            .off  (off),
            .info (info)
        );

        cfg_region_byte #(
            .REGION_SIZE (REGION_SIZE),
            .BAR_IS_IO   (BAR_IS_IO)
        ) u_region (
            .region (info.region),
            .sub    (LSUB),
            .old_b  (old_b),
            .wr_b   (wr_b),
            .new_b  (reg_b)
        );

        always_comb begin
            unique case (info.kind)
                BK_FREE:    nv = wr_b;
                BK_CMD_HI:  nv = (old_b & CMD_HI_KEEP) | (wr_b & ~CMD_HI_KEEP);
                BK_STAT_HI: nv = old_b & ~(wr_b & STAT_HI_W1C);
                BK_REGION:  nv = reg_b;
                default:    nv = old_b;
            endcase
        end

        assign lane_new[l] = nv;
        assign lane_map[l] = wr_en && wr_be[l] && info.map_hit;
    end

    // status high byte: write clear first, event set last (set wins)
    logic [7:0] stat_hi_next;
    always_comb begin
        stat_hi_next = hdr_q[OFF_STAT_HI];
        if (wr_en && wr_dw == OFF_STAT_HI[OFF_W-1:2] && wr_be[OFF_STAT_HI[1:0]])
            stat_hi_next = lane_new[OFF_STAT_HI[1:0]];
        stat_hi_next = stat_hi_next | (stat_evt & STAT_HI_W1C);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < HDR_BYTES; i++) hdr_q[i] <= init_byte(i);
        end else begin
            for (int l = 0; l < LANES; l++) begin
                if (wr_en && wr_be[l]) hdr_q[{wr_dw, 2'(l)}] <= lane_new[l];
            end
            hdr_q[OFF_STAT_HI] <= stat_hi_next;
        end
    end

    always_comb begin
        for (int l = 0; l < LANES; l++) rd_data[8*l +: 8] = hdr_q[{rd_dw, 2'(l)}];
    end

    cfg_update_fsm u_upd (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig    (|lane_map),
        .map_upd (map_upd)
    );

    // R5
    cmd_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(hdr_q[OFF_CMD_HI] & CMD_HI_KEEP));

    // R2
    rev_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(hdr_q[OFF_REV]));

    // R6
    stat_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(hdr_q[OFF_STAT_LO]));

    // R7
    evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        |(stat_evt & STAT_HI_W1C) |=>
        ((hdr_q[OFF_STAT_HI] & $past(stat_evt & STAT_HI_W1C)) == $past(stat_evt & STAT_HI_W1C)));

    // R8
    if (!BAR_IS_IO[0]) begin : g_bar0_chk
        bar0_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cls == HC_ENDPOINT) |-> $stable(hdr_q[OFF_BAR0][3:0]));
    end

endmodule

// File: tb/cfghdr_wpolicy_test.sv
`timescale 1ns/1ps
module cfghdr_wpolicy_test;

    localparam logic [15:0]       VID  = 16'hA5C3;
    localparam logic [15:0]       DID  = 16'h7E01;
    localparam logic [7:0]        REV  = 8'h03, PIF = 8'h01, SUBC = 8'h80, BCLS = 8'h0C;
    localparam logic [7:0]        CAPP = 8'h40, IPIN = 8'h01, STLO = 8'h10;
    localparam logic [1:0]        DVS  = 2'b01;
    localparam logic [6:0][31:0]  RSZ  = {32'd2048, 32'd0, 32'd256, 32'd16, 32'd0, 32'd32, 32'd4096};
    localparam logic [5:0]        RIO  = 6'b010010;
    localparam logic [3:0][7:0]   HT   = {8'h7F, 8'h01, 8'h80, 8'h00};

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [3:0]  wr_dw, wr_be, rd_dw;
    logic [31:0] wr_data;
    logic [7:0]  stat_evt;
    logic [31:0] rd_q  [4];
    logic        upd_q [4];

    always #2.5 clk = ~clk;

    for (genvar t = 0; t < 4; t++) begin : g_dut
        cfghdr_wpolicy #(
            .HDR_TYPE(HT[t]), .VENDOR_ID(VID), .DEVICE_ID(DID), .REV_ID(REV),
            .PROG_IF(PIF), .SUB_CLASS(SUBC), .BASE_CLASS(BCLS), .CAP_PTR(CAPP),
            .INT_PIN(IPIN), .STATUS_LO(STLO), .DEVSEL(DVS),
            .REGION_SIZE(RSZ), .BAR_IS_IO(RIO)
        ) uut (
            .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_dw(wr_dw), .wr_be(wr_be),
            .wr_data(wr_data), .stat_evt(stat_evt), .rd_dw(rd_dw),
            .rd_data(rd_q[t]), .map_upd(upd_q[t])
        );
    end

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] m [4][64];
    logic       mapx [4];

    task automatic chk(input string tag, input int t, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s inst%0d: got %h expected %h", tag, t, got, exp);
        end
    endtask

    // 0 fixed, 1 free, 2 command high, 3 status high, 4+r address region r
    function automatic int kind_of(input int t, input int off);
        if (t == 3) return 0;
        if (off inside {6, 8, 9, 10, 11, 14, 61}) return 0;
        if (off == 52) return (t == 2) ? 1 : 0;
        if (off == 5) return 2;
        if (off == 7) return 3;
        if (t != 2 && off >= 16 && off < 40) return 4 + (off - 16) / 4;
        if (t != 2 && off >= 48 && off < 52) return 10;
        if (t == 2 && off >= 56 && off < 60) return 0;
        return 1;
    endfunction

    function automatic logic [7:0] region_byte(input int r, input int sub, input logic [7:0] o, input logic [7:0] d);
        logic [31:0] keep32;
        logic [7:0]  keep;
        if (RSZ[r] == 0) return o;
        keep32 = (RSZ[r] - 1) | ((r < 6 && RIO[r]) ? 32'h3 : 32'hF);
        keep   = 8'(keep32 >> (8 * sub));
        return (d & ~keep) | (o & keep);
    endfunction

    function automatic logic [31:0] mdw(input int t, input int dw);
        return {m[t][dw*4+3], m[t][dw*4+2], m[t][dw*4+1], m[t][dw*4]};
    endfunction

    task automatic model_reset();
        for (int t = 0; t < 4; t++) begin
            for (int i = 0; i < 64; i++) m[t][i] = 8'h00;
            m[t][0] = VID[7:0]; m[t][1] = VID[15:8]; m[t][2] = DID[7:0]; m[t][3] = DID[15:8];
            m[t][6] = STLO; m[t][7] = {5'b0, DVS, 1'b0};
            m[t][8] = REV; m[t][9] = PIF; m[t][10] = SUBC; m[t][11] = BCLS;
            m[t][14] = HT[t]; m[t][52] = CAPP; m[t][61] = IPIN;
            if (t < 2) for (int k = 0; k < 6; k++) m[t][16+4*k] = {7'b0, RIO[k]};
        end
    endtask

    task automatic model_apply(input int dw, input logic [3:0] be, input logic [31:0] d, input logic [7:0] ev);
        for (int t = 0; t < 4; t++) begin
            mapx[t] = 1'b0;
            for (int l = 0; l < 4; l++) begin
                if (be[l]) begin
                    int off, k;
                    logic [7:0] db;
                    off = dw * 4 + l;
                    k   = kind_of(t, off);
                    db  = d[8*l +: 8];
                    case (k)
                        0: ;
                        1: m[t][off] = db;
                        2: m[t][off] = (m[t][off] & 8'hF8) | (db & 8'h07);
                        3: m[t][off] = m[t][off] & ~(db & 8'hF9);
                        default: m[t][off] = region_byte(k - 4, l, m[t][off], db);
                    endcase
                    if (((off == 4 || off == 5) && t != 3) || k >= 4) mapx[t] = 1'b1;
                end
            end
            m[t][7] = m[t][7] | (ev & 8'hF9);
        end
    endtask

    task automatic op(input int dw, input logic [3:0] be, input logic [31:0] d,
                      input logic [7:0] ev, input string tag);
        @(negedge clk);
        wr_en = 1'b1; wr_dw = 4'(dw); wr_be = be; wr_data = d; stat_evt = ev; rd_dw = 4'(dw);
        model_apply(dw, be, d, ev);
        @(negedge clk);
        wr_en = 1'b0; stat_evt = 8'h00;
        for (int t = 0; t < 4; t++) begin
            chk(tag, t, rd_q[t], mdw(t, dw));
            chk("R12 update pulse", t, {31'b0, upd_q[t]}, {31'b0, mapx[t]});
        end
    endtask

    task automatic rd(input int dw);
        @(negedge clk);
        rd_dw = 4'(dw);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        rst_n = 1'b0; wr_en = 1'b0; wr_dw = '0; wr_be = '0; wr_data = '0; stat_evt = '0; rd_dw = '0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset image on every variant
        for (int dw = 0; dw < 16; dw++) begin
            rd(dw);
            for (int t = 0; t < 4; t++) chk("R1 reset", t, rd_q[t], mdw(t, dw));
        end
        chk("R12 idle after reset", 0, {31'b0, upd_q[0]}, 32'd0);

        // R2 identity/class bytes fixed, ordinary bytes free
        op(2, 4'hF, 32'hFFFF_FFFF, 8'h00, "R2 class bytes");
        op(3, 4'hF, 32'h5A5A_5A5A, 8'h00, "R2 cache/latency/header");
        op(15, 4'hF, 32'hFFFF_FFFF, 8'h00, "R2 interrupt line/pin");
        op(13, 4'hF, 32'h0000_005A, 8'h00, "R3 capability pointer");
        op(14, 4'hF, 32'hC3C3_C3C3, 8'h00, "R3 bridge ROM fixed");
        rd(13);
        chk("R3 bridge cap writable", 2, rd_q[2], 32'h0000_005A);
        chk("R2 endpoint cap fixed", 1, rd_q[1], {24'h0, CAPP});

        // R5 command reserved bits
        op(1, 4'b0011, 32'h0000_FFFF, 8'h00, "R5 command");
        chk("R5 command value", 0, rd_q[0] & 32'h0000_FFFF, 32'h0000_07FF);
        chk("R4 locked command", 3, rd_q[3] & 32'h0000_FFFF, 32'h0000_0000);

        // R7 events, R6 write-one-clear, R7 set beats clear
        op(1, 4'b0000, 32'h0, 8'hFF, "R7 event set");
        op(1, 4'b1100, 32'h01FF_0000, 8'h00, "R6 status clear");
        op(1, 4'b1000, 32'hFF00_0000, 8'h08, "R7 set wins over clear");
        chk("R7 status high", 0, {24'h0, rd_q[0][31:24]}, 32'h0000_000A);
        chk("R4 locked status", 3, {24'h0, rd_q[3][31:24]}, 32'h0000_00FB);

        // R8 / R9 sizing writes
        for (int dw = 4; dw < 10; dw++) op(dw, 4'hF, 32'hFFFF_FFFF, 8'h00, "R8 sizing");
        rd(4);  chk("R8 memory 4K", 0, rd_q[0], 32'hFFFF_F000);
        chk("R3 bridge plain", 2, rd_q[2], 32'hFFFF_FFFF);
        rd(5);  chk("R8 io 32", 0, rd_q[0], 32'hFFFF_FFE1);
        rd(6);  chk("R9 size zero", 0, rd_q[0], 32'h0000_0000);
        rd(8);  chk("R8 io 256", 1, rd_q[1], 32'hFFFF_FF01);
        op(5, 4'hF, 32'h1234_5678, 8'h00, "R8 io address");
        chk("R8 io address value", 0, rd_q[0], 32'h1234_5661);

        // R10 expansion ROM
        op(12, 4'hF, 32'hFFFF_FFFF, 8'h00, "R10 rom");
        chk("R10 rom sized", 0, rd_q[0], 32'hFFFF_F800);
        chk("R3 bridge 0x30 plain", 2, rd_q[2], 32'hFFFF_FFFF);

        // R11 lane enables
        op(4, 4'b0100, 32'h0, 8'h00, "R11 single lane");
        chk("R11 lane value", 0, rd_q[0], 32'hFF00_F000);
        op(15, 4'b0000, 32'h0, 8'h00, "R11 no lanes");
        op(3, 4'hF, 32'h1111_1111, 8'h00, "R12 no pulse on plain bytes");

        // constrained random traffic against the model
        for (int i = 0; i < 600; i++) begin
            logic [31:0] d;
            logic [7:0]  ev;
            d  = ($urandom % 4 == 0) ? 32'hFFFF_FFFF : $urandom;
            ev = ($urandom % 8 == 0) ? 8'($urandom) : 8'h00;
            op($urandom % 16, 4'($urandom), d, ev, "R11 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule